// File: doc/BRIEF.md
# Shared Charge-Pump Power Controller

This block decides when a charge pump shared by two flash banks is powered. The pump is either asleep (lowest power) or active (highest power). Any read access from either side and any erase or program command wakes the pump. So does either bank being in standby or active mode. Waking is not instant. A down counter, loaded with a programmable wake value, steps once per prescaled system-clock tick. The pump reports ready only when that counter reaches zero. Requests are granted only while the pump is ready, so requesters simply hold their request until the grant appears.

Once the pump is active, a grace counter keeps it powered for a programmable number of system-clock cycles after the last reason to stay on. The counter is reloaded and frozen for as long as either bank is active or any request is present. It counts down only when neither holds. When it has expired, the pump returns to sleep only if both banks are asleep and both owners have set their sleep-request bits. Otherwise it stays active.

Top module: `pump_pwr_ctrl`

## Requirements
- R1: While the reset is asserted and just after it, pump_mode, pump_ready, acc_gnt and pe_gnt are all 0.
- R2: A pump that is asleep stays asleep while nothing demands it. Demand is any acc_req bit, pe_req, or either bank state other than sleep. Bank state codes are 00 sleep, 01 standby, 10 active, and 11 is treated as active.
- R3: When demand is first sampled at a clock edge while asleep, pump_mode is 1 from that edge onward. pump_ready rises exactly 1 + D*(P+1) edges later, where D is wake_dly and P is presc_div. The prescaled tick period is P+1 system cycles.
- R4: During the wake delay, pump_mode is 1 and pump_ready is 0. pump_ready implies pump_mode.
- R5: acc_gnt equals acc_req masked by pump_ready, and pe_gnt equals pe_req masked by pump_ready.
- R6: While the pump is ready and either bank is in standby or active mode, the pump stays ready.
- R7: While either bank is active or any request is present, the grace counter is held at grace_cnt. The countdown starts at the first edge at which neither holds. With G = grace_cnt, the pump sleeps at the (G+1)-th edge of an uninterrupted idle stretch.
- R8: If a bank becomes active during the countdown, the counter is reinitialised. The full G+1 edges are counted again from the end of that activity.
- R9: The pump enters sleep only when both sleep_en bits are 1 and both banks are asleep. Otherwise it stays ready indefinitely after the grace count expires. Setting the missing bit after expiry puts the pump to sleep at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bank_st_a | input | 2 | Power state of bank A (00 sleep, 01 standby, 1x active) |
| bank_st_b | input | 2 | Power state of bank B, same coding |
| acc_req | input | 2 | Read access request, one bit per bank |
| pe_req | input | 1 | Erase or program command request |
| sleep_en_a | input | 1 | Owner A permits pump sleep |
| sleep_en_b | input | 1 | Owner B permits pump sleep |
| wake_dly | input | WDLY_W | Wake delay in prescaled ticks, loaded on leaving sleep |
| presc_div | input | PDIV_W | Prescaler setting; tick period is presc_div+1 cycles |
| grace_cnt | input | GRACE_W | Idle cycles granted before the pump may sleep |
| pump_mode | output | 1 | 1 when the pump has left sleep (waking or active) |
| pump_ready | output | 1 | 1 when the pump is fully active |
| acc_gnt | output | 2 | Access grants, per bank |
| pe_gnt | output | 1 | Erase/program grant |

## Verification
The bench sweeps every wake delay against every prescaler setting and measures the exact edge at which ready rises. A design whose prescaler counts from the wrong phase, or that skips the final zero check, is off by one or by a full tick period. It sweeps every grace count and checks the sleep edge. Counting a bank's standby as a hold, or reloading one cycle late, moves that edge. It also interrupts a countdown with bank activity and withholds one owner's sleep bit. A design that resumes rather than restarts the count, or that sleeps on a single owner's consent, fails there.

// File: rtl/pump_pkg.sv
package pump_pkg;
  typedef enum logic [1:0] {
    PS_SLEEP = 2'b00,
    PS_WAKE  = 2'b01,
    PS_ON    = 2'b10
  } pump_st_e;

  localparam logic [1:0] BK_SLEEP   = 2'b00;
  localparam logic [1:0] BK_STANDBY = 2'b01;

  function automatic logic bank_busy(input logic [1:0] st);
    return st != BK_SLEEP;
  endfunction

  function automatic logic bank_act(input logic [1:0] st);
    return st[1];
  endfunction
endpackage

// File: rtl/pump_rst_sync.sv
module pump_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] shf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shf_q <= '0;
    else        shf_q <= {shf_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = shf_q[STAGES-1];
endmodule

// File: rtl/pump_presc.sv
module pump_presc #(
  parameter int PDIV_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [PDIV_W-1:0] div,
  output logic              tick
);
  logic [PDIV_W-1:0] pc_q, pc_d;

  assign tick = (pc_q == div);

  always_comb begin
    if (clr || tick) pc_d = '0;
    else             pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/pump_dcnt.sv
module pump_dcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] init,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         en;

  assign zero = (cnt_q == '0);
  assign en   = load || (dec && !zero);

  always_comb begin
    if (load) cnt_d = init;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pump_pwr_ctrl.sv
module pump_pwr_ctrl
  import pump_pkg::*;
#(
  parameter int NBANK   = 2,
  parameter int WDLY_W  = 8,
  parameter int PDIV_W  = 4,
  parameter int GRACE_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         bank_st_a,
  input  logic [1:0]         bank_st_b,
  input  logic [NBANK-1:0]   acc_req,
  input  logic               pe_req,
  input  logic               sleep_en_a,
  input  logic               sleep_en_b,
  input  logic [WDLY_W-1:0]  wake_dly,
  input  logic [PDIV_W-1:0]  presc_div,
  input  logic [GRACE_W-1:0] grace_cnt,
  output logic               pump_mode,
  output logic               pump_ready,
  output logic [NBANK-1:0]   acc_gnt,
  output logic               pe_gnt
);
  pump_st_e st_q, st_d;
  logic     rst_n_i;
  logic     any_req, any_busy, any_act, demand, hold_grace, sleep_ok;
  logic     tick, wake_zero, grace_zero;

  pump_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  assign any_req    = (|acc_req) || pe_req;
  assign any_busy   = bank_busy(bank_st_a) || bank_busy(bank_st_b);
  assign any_act    = bank_act(bank_st_a) || bank_act(bank_st_b);
  assign demand     = any_req || any_busy;
  assign hold_grace = (st_q != PS_ON) || any_act || any_req;
  assign sleep_ok   = sleep_en_a && sleep_en_b && !any_busy;

  pump_presc #(.PDIV_W(PDIV_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n_i),
    .clr   (st_q != PS_WAKE),
    .div   (presc_div),
    .tick  (tick)
  );

  pump_dcnt #(.W(WDLY_W)) u_wake (
    .clk   (clk),
    .rst_n (rst_n_i),
    .load  (st_q == PS_SLEEP),
    .init  (wake_dly),
    .dec   ((st_q == PS_WAKE) && tick),
    .zero  (wake_zero)
  );

  pump_dcnt #(.W(GRACE_W)) u_grace (
    .clk   (clk),
    .rst_n (rst_n_i),
    .load  (hold_grace),
    .init  (grace_cnt),
    .dec   (1'b1),
    .zero  (grace_zero)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PS_SLEEP: if (demand) st_d = PS_WAKE;
      PS_WAKE:  if (wake_zero) st_d = PS_ON;
      PS_ON:    if (!hold_grace && grace_zero && sleep_ok) st_d = PS_SLEEP;
      default:  st_d = PS_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) st_q <= PS_SLEEP;
    else          st_q <= st_d;
  end

  assign pump_mode  = (st_q != PS_SLEEP);
  assign pump_ready = (st_q == PS_ON);
  assign acc_gnt    = acc_req & {NBANK{pump_ready}};
  assign pe_gnt     = pe_req && pump_ready;
endmodule

// File: rtl/pump_pwr_chk.sv
module pump_pwr_chk #(
  parameter int NBANK = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       bank_st_a,
  input logic [1:0]       bank_st_b,
  input logic [NBANK-1:0] acc_req,
  input logic             pe_req,
  input logic             sleep_en_a,
  input logic             sleep_en_b,
  input logic             pump_mode,
  input logic             pump_ready,
  input logic [NBANK-1:0] acc_gnt,
  input logic             pe_gnt
);
  logic busy, dem;
  assign busy = (bank_st_a != 2'b00) || (bank_st_b != 2'b00);
  assign dem  = busy || (|acc_req) || pe_req;

  a_r4_ready_has_mode: assert property (@(posedge clk) disable iff (!rst_n)
    pump_ready |-> pump_mode);

  a_r4_wake_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pump_mode) |-> !pump_ready);

  a_r5_grant_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ((|acc_gnt) || pe_gnt) |-> pump_ready);

  a_r2_idle_stays_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    (!pump_mode && !dem) |=> !pump_mode);

  a_r6_busy_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_ready && busy) |=> pump_ready);

  a_r9_sleep_consent: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_ready && !(sleep_en_a && sleep_en_b)) |=> pump_mode);
endmodule

bind pump_pwr_ctrl pump_pwr_chk #(.NBANK(NBANK)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bank_st_a  (bank_st_a),
  .bank_st_b  (bank_st_b),
  .acc_req    (acc_req),
  .pe_req     (pe_req),
  .sleep_en_a (sleep_en_a),
  .sleep_en_b (sleep_en_b),
  .pump_mode  (pump_mode),
  .pump_ready (pump_ready),
  .acc_gnt    (acc_gnt),
  .pe_gnt     (pe_gnt)
);

// File: tb/sim_pump_pwr_ctrl.sv
module sim_pump_pwr_ctrl;
  localparam int WDLY_W = 3, PDIV_W = 2, GRACE_W = 3;

  logic clk, rst_n;
  logic [1:0] bank_st_a, bank_st_b, acc_req, acc_gnt;
  logic pe_req, sleep_en_a, sleep_en_b, pump_mode, pump_ready, pe_gnt;
  logic [WDLY_W-1:0]  wake_dly;
  logic [PDIV_W-1:0]  presc_div;
  logic [GRACE_W-1:0] grace_cnt;
  int checks, errs;

  pump_pwr_ctrl #(.NBANK(2), .WDLY_W(WDLY_W), .PDIV_W(PDIV_W), .GRACE_W(GRACE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .bank_st_a(bank_st_a), .bank_st_b(bank_st_b),
    .acc_req(acc_req), .pe_req(pe_req), .sleep_en_a(sleep_en_a), .sleep_en_b(sleep_en_b),
    .wake_dly(wake_dly), .presc_div(presc_div), .grace_cnt(grace_cnt),
    .pump_mode(pump_mode), .pump_ready(pump_ready), .acc_gnt(acc_gnt), .pe_gnt(pe_gnt));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic go_sleep();
    acc_req = '0; pe_req = 0; bank_st_a = 2'b00; bank_st_b = 2'b00;
    sleep_en_a = 1; sleep_en_b = 1;
    for (int i = 0; i < 40 && pump_mode; i++) @(negedge clk);
  endtask

  task automatic go_ready();
    acc_req = 2'b01;
    for (int i = 0; i < 60 && !pump_ready; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic count_to_sleep(output int n);
    n = 0;
    while (n < 40) begin
      @(negedge clk); n++;
      if (!pump_mode) break;
    end
  endtask

  initial begin
    #1500000;
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int n;
    logic bad;
    checks = 0; errs = 0;
    rst_n = 0; acc_req = '0; pe_req = 0; bank_st_a = '0; bank_st_b = '0;
    sleep_en_a = 1; sleep_en_b = 1; wake_dly = '0; presc_div = '0; grace_cnt = '0;
    repeat (3) @(negedge clk);
    chk(!pump_mode && !pump_ready && acc_gnt == 0 && !pe_gnt, "R1 reset outputs", pump_mode, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(!pump_mode && !pump_ready, "R1 after release", pump_ready, 0);
    chk(!pump_mode, "R2 no demand stays asleep", pump_mode, 0);

    // R3/R4/R5: wake latency sweep
    for (int d = 0; d < 8; d++) begin
      for (int p = 0; p < 4; p++) begin
        go_sleep();
        wake_dly = d[WDLY_W-1:0]; presc_div = p[PDIV_W-1:0];
        acc_req = 2'b10;
        n = 0; bad = 0;
        while (n < 60) begin
          @(posedge clk); @(negedge clk); n++;
          if (!pump_mode) bad = 1;
          if (!pump_ready && acc_gnt != 0) bad = 1;
          if (pump_ready) break;
        end
        chk(n == 2 + d * (p + 1), $sformatf("R3 wake d=%0d p=%0d", d, p), n, 2 + d * (p + 1));
        chk(!bad, "R4 mode high, no grant during wake", bad, 0);
        chk(acc_gnt == 2'b10, "R5 grant at ready", acc_gnt, 2);
      end
    end

    // R2: other demand sources
    wake_dly = 0; presc_div = 0;
    go_sleep(); pe_req = 1; repeat (3) @(negedge clk);
    chk(pump_ready && pe_gnt, "R2 pe wakes, R5 pe_gnt", pe_gnt, 1);
    go_sleep(); bank_st_b = 2'b10; repeat (3) @(negedge clk);
    chk(pump_ready, "R2 bank active wakes", pump_ready, 1);
    go_sleep(); bank_st_a = 2'b01; repeat (3) @(negedge clk);
    chk(pump_ready, "R2 bank standby wakes", pump_ready, 1);

    // R7: grace sweep
    for (int g = 0; g < 8; g++) begin
      go_sleep(); grace_cnt = g[GRACE_W-1:0]; go_ready();
      acc_req = '0;
      count_to_sleep(n);
      chk(n == g + 1, $sformatf("R7 grace g=%0d", g), n, g + 1);
    end

    // R8: reload on activity mid-countdown
    go_sleep(); grace_cnt = 5; go_ready();
    acc_req = '0; repeat (2) @(negedge clk);
    bank_st_a = 2'b10; @(negedge clk);
    chk(pump_ready, "R8 still ready mid-count", pump_ready, 1);
    bank_st_a = 2'b00;
    count_to_sleep(n);
    chk(n == 6, "R8 countdown restarted", n, 6);

    // R6: standby keeps pump ready
    go_sleep(); grace_cnt = 2; go_ready();
    bank_st_b = 2'b01; acc_req = '0;
    repeat (12) @(negedge clk);
    chk(pump_ready, "R6 standby holds ready", pump_ready, 1);
    bank_st_b = 2'b00; @(negedge clk);
    chk(!pump_mode, "R6 sleep once standby ends after expiry", pump_mode, 0);

    // R9: both owners must consent
    go_sleep(); grace_cnt = 1; go_ready();
    sleep_en_b = 0; acc_req = '0;
    repeat (12) @(negedge clk);
    chk(pump_ready, "R9 one owner withholds", pump_ready, 1);
    sleep_en_a = 0; sleep_en_b = 1; repeat (4) @(negedge clk);
    chk(pump_ready, "R9 other owner withholds", pump_ready, 1);
    sleep_en_a = 1; @(negedge clk);
    chk(!pump_mode, "R9 sleep next edge after consent", pump_mode, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule